// File: doc/BRIEF.md
# Microwire EEPROM Read Master

This block fetches a run of consecutive 16-bit words from a serial EEPROM of the common three-wire-plus-select kind. The host presents a first address, a word count and an address-width choice (6 or 8 bits), then pulses `start`. For every word the block runs a complete read transaction on the serial pins. It raises chip select, sends a start bit and the read opcode, and then sends the address. It clocks in seventeen data bits and drops the leading dummy bit. Each finished word appears on `word_data` with a one-cycle `word_valid` strobe.

The serial clock is made from the system clock by a phase timer. The high and low times, and the extra chip-select-low time between transactions, are parameters counted in system-clock cycles. The incoming data line passes through a configurable synchroniser and is sampled in the last cycle of each clock-low phase. After every word, chip select falls and one full serial clock pulse is given with it low. The extra low time follows, and only then does the next word's transaction begin.

Top module: `uwire_eeprom_reader`

## Requirements
- R1: While reset is asserted and afterwards with no request, `ee_cs`, `ee_sck`, `ee_dout`, `busy`, `done` and `word_valid` are all low.
- R2: Each word transaction raises `ee_cs` while `ee_sck` is low. The first rising `ee_sck` edge after that carries `ee_dout`=0, and the next three carry 1, 1, 0 (start bit, then read opcode `10`). `ee_dout` never changes while `ee_sck` is high.
- R3: The address follows MSB first: 6 bits when `wide_addr`=0 and 8 bits when `wide_addr`=1. In 6-bit mode, bits 7:6 of `start_addr` are ignored. Word i of a request uses address (`start_addr`+i) modulo 2^width.
- R4: After the address, exactly 17 rising `ee_sck` edges occur with `ee_cs` high. `ee_din` is sampled just before each of these rising edges. The first sample is discarded, and the remaining 16 form `word_data` MSB first.
- R5: While `ee_cs` is high, every high phase of `ee_sck` lasts exactly SCK_HI_CYC cycles and every low phase lasts exactly SCK_LO_CYC cycles.
- R6: Between two words of one request, `ee_cs` stays low for exactly SCK_LO_CYC+SCK_HI_CYC+CS_GAP_CYC cycles. This time includes one complete `ee_sck` pulse.
- R7: `word_valid` is high for exactly one cycle per word, with `ee_cs` low. A request yields exactly `word_count` strobes.
- R8: `busy` is high from the cycle after an accepted `start` until the request ends. `done` then pulses for one cycle with `busy` already low.
- R9: A `start` pulse while `busy` is high is ignored, together with the address and count presented with it.
- R10: A request with `word_count`=0 gives `done` in the cycle after `start`, with `busy` low and no `ee_sck` edge.
- R11: A `start` presented in the cycle in which `done` is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| start_addr | input | ADDR_W_MAX | First word address |
| word_count | input | COUNT_W | Number of words to read |
| wide_addr | input | 1 | 1 selects 8-bit addresses, 0 selects 6-bit |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| word_valid | output | 1 | One-cycle strobe for `word_data` |
| word_data | output | WORD_W | Last assembled word |
| ee_cs | output | 1 | Serial chip select, active high |
| ee_sck | output | 1 | Serial clock |
| ee_dout | output | 1 | Serial data to the memory |
| ee_din | input | 1 | Serial data from the memory |

## Verification
The end of one request and the acceptance of the next can fall in the same cycle. This happens when `start` arrives while `done` is high, because the sequencer already counts as idle then. The bench watches for the `done` pulse and drives a new `start` with fresh address and count in that same cycle. The new request is judged accepted if `busy` reads high one cycle later and if the behavioural memory model sees the new addresses and returns the right number of correct words.

// File: rtl/uwr_pkg.sv
`timescale 1ns/1ps
package uwr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_CMD,
      ST_ADDR,
      ST_DATA,
      ST_GAP,
      ST_TAIL
   } uwr_state_e;

   // start bit followed by the two read opcode bits, sent from bit 2 down
   localparam logic [2:0] READ_SEQ = 3'b110;

endpackage

// File: rtl/uwr_phase_timer.sv
`timescale 1ns/1ps
module uwr_phase_timer #(
   parameter int LO_CYC = 2,
   parameter int HI_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sck_q,
   output logic rise_now,
   output logic fall_now
);
   localparam int TMAX = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
   localparam int TW   = $clog2(TMAX + 1);
   localparam logic [TW-1:0] LO_LAST = TW'(LO_CYC - 1);
   localparam logic [TW-1:0] HI_LAST = TW'(HI_CYC - 1);

   logic [TW-1:0] cnt;

   always_comb begin
      rise_now = run && !sck_q && (cnt == LO_LAST);
      fall_now = run &&  sck_q && (cnt == HI_LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sck_q <= 1'b0;
      end else if (!run) begin
         cnt   <= '0;
         sck_q <= 1'b0;
      end else if (rise_now) begin
         cnt   <= '0;
         sck_q <= 1'b1;
      end else if (fall_now) begin
         cnt   <= '0;
         sck_q <= 1'b0;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/uwr_rx_shift.sv
`timescale 1ns/1ps
module uwr_rx_shift #(
   parameter int WORD_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic              sample_en,
   output logic [WORD_W-1:0] word
);
   logic din_s;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign din_s = din;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= (chain << 1) | SYNC_STAGES'(din);
         end
         assign din_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   // seventeen shifts leave the leading dummy bit off the top
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         word <= '0;
      else if (sample_en) word <= {word[WORD_W-2:0], din_s};
   end
endmodule

// File: rtl/uwire_eeprom_reader.sv
`timescale 1ns/1ps
module uwire_eeprom_reader
   import uwr_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int ADDR_W_MAX = 8,
   parameter int NARROW_AW  = 6,
   parameter int COUNT_W    = 9,
   parameter int SCK_HI_CYC = 188,
   parameter int SCK_LO_CYC = 63,
   parameter int CS_GAP_CYC = 250,
   parameter int DIN_SYNC   = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [ADDR_W_MAX-1:0] start_addr,
   input  logic [COUNT_W-1:0]    word_count,
   input  logic                  wide_addr,
   output logic                  busy,
   output logic                  done,
   output logic                  word_valid,
   output logic [WORD_W-1:0]     word_data,
   output logic                  ee_cs,
   output logic                  ee_sck,
   output logic                  ee_dout,
   input  logic                  ee_din
);
   localparam int AI_W  = $clog2(ADDR_W_MAX);
   localparam int IDX_W = $clog2(WORD_W + 1);
   localparam int GAP_W = $clog2(CS_GAP_CYC + 1);
   localparam logic [ADDR_W_MAX-1:0] MASK_WIDE   = '1;
   localparam logic [ADDR_W_MAX-1:0] MASK_NARROW = ADDR_W_MAX'((1 << NARROW_AW) - 1);
   localparam logic [IDX_W-1:0] LAST_DATA  = IDX_W'(WORD_W);
   localparam logic [IDX_W-1:0] LAST_CMD   = IDX_W'(2);
   localparam logic [IDX_W-1:0] AW_LAST_W  = IDX_W'(ADDR_W_MAX - 1);
   localparam logic [IDX_W-1:0] AW_LAST_N  = IDX_W'(NARROW_AW - 1);
   localparam logic [GAP_W-1:0] GAP_LAST   = GAP_W'(CS_GAP_CYC - 1);

   generate
      if (SCK_HI_CYC < 1 || SCK_LO_CYC < 1 || CS_GAP_CYC < 1) begin : g_bad_timing
         $error("serial clock phases and chip-select gap need at least one cycle");
      end
      if (NARROW_AW < 1 || NARROW_AW > ADDR_W_MAX) begin : g_bad_aw
         $error("narrow address width must lie within the wide width");
      end
      if (WORD_W < ADDR_W_MAX || WORD_W < 3) begin : g_bad_word
         $error("word width must cover the address bit index");
      end
      if (DIN_SYNC >= SCK_HI_CYC + SCK_LO_CYC) begin : g_bad_sync
         $error("input synchroniser longer than one serial clock period");
      end
   endgenerate

   uwr_state_e            state;
   logic [ADDR_W_MAX-1:0] cur_addr;
   logic [COUNT_W-1:0]    left;
   logic                  wide_q;
   logic [IDX_W-1:0]      bit_idx;
   logic [GAP_W-1:0]      gap_cnt;
   logic                  slot_run;
   logic                  rise_now;
   logic                  fall_now;
   logic                  sample_en;
   logic [2:0]            cmd_sh;
   logic [ADDR_W_MAX-1:0] addr_mask;
   logic [ADDR_W_MAX-1:0] in_mask;

   always_comb begin
      slot_run  = (state == ST_SETUP) || (state == ST_CMD) || (state == ST_ADDR) ||
                  (state == ST_DATA)  || (state == ST_GAP);
      ee_cs     = (state == ST_SETUP) || (state == ST_CMD) || (state == ST_ADDR) ||
                  (state == ST_DATA);
      busy      = (state != ST_IDLE);
      sample_en = (state == ST_DATA) && rise_now;
      addr_mask = wide_q    ? MASK_WIDE : MASK_NARROW;
      in_mask   = wide_addr ? MASK_WIDE : MASK_NARROW;
      cmd_sh    = READ_SEQ << bit_idx[1:0];
      ee_dout   = 1'b0;
      if (state == ST_CMD)       ee_dout = cmd_sh[2];
      else if (state == ST_ADDR) ee_dout = cur_addr[bit_idx[AI_W-1:0]];
   end

   uwr_phase_timer #(
      .LO_CYC (SCK_LO_CYC),
      .HI_CYC (SCK_HI_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (slot_run),
      .sck_q    (ee_sck),
      .rise_now (rise_now),
      .fall_now (fall_now)
   );

   uwr_rx_shift #(
      .WORD_W      (WORD_W),
      .SYNC_STAGES (DIN_SYNC)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .din       (ee_din),
      .sample_en (sample_en),
      .word      (word_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         cur_addr   <= '0;
         left       <= '0;
         wide_q     <= 1'b0;
         bit_idx    <= '0;
         gap_cnt    <= '0;
         word_valid <= 1'b0;
         done       <= 1'b0;
      end else begin
         word_valid <= 1'b0;
         done       <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  if (word_count == '0) begin
                     done <= 1'b1;
                  end else begin
                     cur_addr <= start_addr & in_mask;
                     left     <= word_count;
                     wide_q   <= wide_addr;
                     state    <= ST_SETUP;
                  end
               end
            end
            ST_SETUP: begin
               if (fall_now) begin
                  bit_idx <= '0;
                  state   <= ST_CMD;
               end
            end
            ST_CMD: begin
               if (fall_now) begin
                  if (bit_idx == LAST_CMD) begin
                     bit_idx <= wide_q ? AW_LAST_W : AW_LAST_N;
                     state   <= ST_ADDR;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                  end
               end
            end
            ST_ADDR: begin
               if (fall_now) begin
                  if (bit_idx == '0) begin
                     state <= ST_DATA;
                  end else begin
                     bit_idx <= bit_idx - 1'b1;
                  end
               end
            end
            ST_DATA: begin
               if (fall_now) begin
                  if (bit_idx == LAST_DATA) begin
                     word_valid <= 1'b1;
                     left       <= left - 1'b1;
                     cur_addr   <= (cur_addr + 1'b1) & addr_mask;
                     state      <= ST_GAP;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (fall_now) begin
                  gap_cnt <= '0;
                  state   <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (gap_cnt == GAP_LAST) begin
                  if (left == '0) begin
                     done  <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     state <= ST_SETUP;
                  end
               end else begin
                  gap_cnt <= gap_cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/uwr_reader_checks.sv
`timescale 1ns/1ps
module uwr_reader_checks (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic word_valid,
   input logic ee_cs,
   input logic ee_sck,
   input logic ee_dout
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!ee_cs && !ee_sck && !ee_dout));

   p_cs_rise_sck_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_cs) |-> !ee_sck);

   p_dout_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ee_sck && $past(ee_sck)) |-> $stable(ee_dout));

   p_cs_fall_sck_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_cs) |-> !ee_sck);

   p_valid_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   p_valid_cs_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |-> (!ee_cs && busy));

   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && !word_valid));
endmodule

bind uwire_eeprom_reader uwr_reader_checks u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .word_valid (word_valid),
   .ee_cs      (ee_cs),
   .ee_sck     (ee_sck),
   .ee_dout    (ee_dout)
);

// File: tb/uwire_eeprom_reader_bench.sv
`timescale 1ns/1ps
module uwire_eeprom_reader_bench;
   localparam int LO  = 2;
   localparam int HI  = 3;
   localparam int GAP = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [7:0] start_addr = '0;
   logic [8:0] word_count = '0;
   logic wide_addr = 1'b0;
   logic busy, done, word_valid, ee_cs, ee_sck, ee_dout, ee_din;
   logic [15:0] word_data;

   always #2 clk = ~clk;

   uwire_eeprom_reader #(
      .WORD_W(16), .ADDR_W_MAX(8), .NARROW_AW(6), .COUNT_W(9),
      .SCK_HI_CYC(HI), .SCK_LO_CYC(LO), .CS_GAP_CYC(GAP), .DIN_SYNC(2)
   ) u_uwire_eeprom_reader (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .word_count(word_count), .wide_addr(wide_addr), .busy(busy), .done(done),
      .word_valid(word_valid), .word_data(word_data), .ee_cs(ee_cs),
      .ee_sck(ee_sck), .ee_dout(ee_dout), .ee_din(ee_din)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] dev_word(input logic [7:0] a);
      return 16'h5A3C ^ {a, ~a} ^ (16'(a) << 3);
   endfunction

   // bookkeeping for the current request
   int aw = 6;
   int mask = 63;
   int run_base = 0;
   int exp_cnt = 0;
   int words_seen = 0;
   int dev_tx = 0;
   bit done_seen = 0;
   int sck_rises = 0;

   // behavioural serial memory
   int dev_n = 0;
   logic [11:0] dev_rx = '0;
   logic [15:0] dev_out = '0;
   logic dev_din = 1'b0;
   assign ee_din = dev_din;

   always @(posedge ee_sck or negedge ee_cs) begin
      if (!ee_cs) begin
         if (dev_n != 0)
            chk(dev_n == 4 + aw + 17, "R4 rising edges per transaction", dev_n, 4 + aw + 17);
         dev_n = 0;
         dev_rx = '0;
         dev_din = 1'b0;
      end else begin
         logic [7:0] got;
         dev_n++;
         dev_rx = {dev_rx[10:0], ee_dout};
         if (dev_n == 4)
            chk(dev_rx[3:0] == 4'b0110, "R2 setup/start/opcode bits", dev_rx[3:0], 4'b0110);
         if (dev_n == 4 + aw) begin
            got = (aw == 8) ? dev_rx[7:0] : {2'b00, dev_rx[5:0]};
            chk(int'(got) == ((run_base + dev_tx) & mask), "R3 address", got,
                (run_base + dev_tx) & mask);
            dev_tx++;
            dev_out = dev_word(got);
            dev_din = 1'b0;
         end else if (dev_n > 4 + aw) begin
            dev_din = dev_out[15];
            dev_out = dev_out << 1;
         end
      end
   end

   // output monitor, sampled at the falling clock edge
   logic prev_sck = 1'b0, prev_cs = 1'b0;
   int hicnt = 0, locnt = 0, gapcnt = 0;
   bit gap_on = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (word_valid) begin
            chk(word_data == dev_word(8'((run_base + words_seen) & mask)), "R4 word data",
                word_data, dev_word(8'((run_base + words_seen) & mask)));
            words_seen++;
         end
         if (done) begin
            chk(words_seen == exp_cnt, "R7 words per request", words_seen, exp_cnt);
            chk(!busy, "R8 busy low with done", busy, 0);
            done_seen = 1;
            gap_on = 0;
         end
         if (ee_sck && !prev_sck) begin
            sck_rises++;
            if (ee_cs) chk(locnt == LO, "R5 low phase", locnt, LO);
         end
         if (!ee_sck && prev_sck) chk(hicnt == HI, "R5 high phase", hicnt, HI);
         if (ee_cs && !prev_cs && gap_on) begin
            chk(gapcnt == LO + HI + GAP, "R6 chip-select gap", gapcnt, LO + HI + GAP);
            gap_on = 0;
         end
         hicnt = ee_sck ? (prev_sck ? hicnt + 1 : 1) : 0;
         if (ee_sck) locnt = 0;
         else if (prev_sck || (ee_cs && !prev_cs)) locnt = 1;
         else locnt = locnt + 1;
         if (!ee_cs && prev_cs) begin gap_on = 1; gapcnt = 1; end
         else if (!ee_cs && gap_on) gapcnt++;
      end
      prev_sck = ee_sck;
      prev_cs = ee_cs;
   end

   // called just after a falling edge
   task automatic launch(input bit wide, input logic [7:0] addr, input logic [8:0] cnt);
      aw = wide ? 8 : 6;
      mask = wide ? 255 : 63;
      run_base = int'(addr) & mask;
      exp_cnt = int'(cnt);
      words_seen = 0;
      dev_tx = 0;
      done_seen = 0;
      wide_addr = wide;
      start_addr = addr;
      word_count = cnt;
      start = 1'b1;
      @(negedge clk);
      if (cnt == 0) begin
         chk(done && !busy, "R10 done next cycle, busy low", {busy, done}, 2'b01);
      end else begin
         chk(busy, "R8 busy after start", busy, 1);
      end
      #1 start = 1'b0;
   endtask

   task automatic wait_done();
      do begin
         @(negedge clk);
         #1;
      end while (!done_seen);
   endtask

   localparam logic [17:0] VECS [4] = '{
      {1'b0, 8'h05, 9'd3},
      {1'b1, 8'hC7, 9'd2},
      {1'b0, 8'hFE, 9'd3},
      {1'b1, 8'hFF, 9'd2}
   };

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int r0;
      repeat (3) @(negedge clk);
      chk({ee_cs, ee_sck, ee_dout, busy, done, word_valid} == 6'b0, "R1 outputs in reset",
          {ee_cs, ee_sck, ee_dout, busy, done, word_valid}, 0);
      #1 rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk({ee_cs, ee_sck, ee_dout, busy, done, word_valid} == 6'b0, "R1 outputs idle",
          {ee_cs, ee_sck, ee_dout, busy, done, word_valid}, 0);

      // vector table: R2..R8 under several widths, addresses and wraps (R3)
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); #1;
         launch(VECS[i][17], VECS[i][16:9], VECS[i][8:0]);
         wait_done();
      end

      // R9: a second start in mid-request must be ignored
      @(negedge clk); #1;
      launch(1'b0, 8'h10, 9'd2);
      repeat (40) @(negedge clk);
      #1;
      start_addr = 8'h20;
      word_count = 9'd5;
      wide_addr = 1'b1;
      start = 1'b1;
      @(negedge clk); #1 start = 1'b0;
      wait_done();
      chk(words_seen == 2, "R9 ignored start leaves word count", words_seen, 2);
      chk(dev_tx == 2, "R9 ignored start leaves transactions", dev_tx, 2);

      // R10: zero count gives immediate done and no serial clock
      repeat (5) @(negedge clk);
      #1;
      r0 = sck_rises;
      launch(1'b0, 8'h07, 9'd0);
      repeat (20) @(negedge clk);
      chk(sck_rises == r0, "R10 no serial clock", sck_rises - r0, 0);
      chk(!busy, "R10 busy stays low", busy, 0);

      // R11: start in the cycle of done
      @(negedge clk); #1;
      launch(1'b1, 8'h80, 9'd1);
      do @(negedge clk); while (!done);
      #1;
      launch(1'b0, 8'h21, 9'd2);
      chk(busy, "R11 start during done accepted", busy, 1);
      wait_done();
      chk(words_seen == 2, "R11 follow-up request word count", words_seen, 2);

      repeat (5) @(negedge clk);
      chk({ee_cs, ee_sck, busy} == 3'b0, "R1 idle after requests", {ee_cs, ee_sck, busy}, 0);
      finish_run();
   end
endmodule